// File: doc/BRIEF.md
# Burst Write Sequence Checker

This block watches the write side of a Wishbone-style slave port and checks every accepted write beat against a predicted address and data stream. Software programs a starting word address, a starting data word and a run length. From then on the block predicts each beat. The word address goes up by one per beat inside a 4 KB window. The data word is the previous prediction rotated left by one bit.

Any beat whose address or data does not match the prediction sets a sticky error flag. There are two flags, one for the address and one for the data. After the programmed number of beats, the prediction goes back to the start values, so a bus master can replay the same burst over and over. A counter records how many beats were checked. Software clears the flags and the counter with separate clear strobes, and a clear takes effect only when the accompanying word is all ones.

The block only observes. It drives nothing onto the bus, and the storage behind the slave is handled elsewhere.

Top module: `burst_seq_checker`

## Requirements
- R1: A beat is checked only in a cycle where busCyc, busStb, busWe and busAck are all 1 and busAdr bit 12 is 0. Any other cycle leaves the status and the beat counter unchanged.
- R2: The predicted word address (busAdr bits 11:2) starts at the programmed start address bits 11:2. It rises by one per checked beat and wraps modulo 1024 inside the 4 KB window. A mismatch sets statusWord bit 1.
- R3: The predicted data word starts at the programmed start data. Each checked beat moves it to the previous prediction rotated left by one bit. A mismatch sets statusWord bit 0.
- R4: The run length comes from cfgData bits 10:0, with valid values 1 to 1024. After that many checked beats, the prediction returns to the start address and start data, so a beat that repeats the start values raises no error.
- R5: statusWord bits 31:2 always read 0. The two flags are set independently, so a single beat can set both (status 3).
- R6: Both flags are sticky. Error-free beats leave them set. They clear one cycle after errClrWe is pulsed with cfgData equal to all ones, and a clear pulse with any other value has no effect.
- R7: beatCount increases by one per checked beat. It reads 0 one cycle after cntClrWe is pulsed with cfgData equal to all ones, and it is unchanged by a clear pulse with any other value.
- R8: A configuration write (cfgWe = 1) loads the register chosen by cfgSel and restarts the prediction from the start values. cfgSel 0 loads the start address from cfgData bits 11:2, cfgSel 1 loads the start data, cfgSel 2 loads the run length, and cfgSel 3 loads nothing.
- R9: After reset, statusWord and beatCount are 0, the start address and start data are 0, and the run length is 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCyc | input | 1 | Bus cycle valid |
| busStb | input | 1 | Bus strobe |
| busWe | input | 1 | Bus write enable |
| busAck | input | 1 | Slave acknowledge |
| busAdr | input | 11 | Bus address bits 12:2 (bit 12 selects register space) |
| busDat | input | 32 | Bus write data |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgData | input | 32 | Configuration / clear value |
| errClrWe | input | 1 | Error flag clear strobe |
| cntClrWe | input | 1 | Beat counter clear strobe |
| statusWord | output | 32 | Bit 1 address error, bit 0 data error |
| beatCount | output | 16 | Checked beat count |

## Verification
If the prediction registers go wrong, the fault shows on statusWord one cycle after the first checked beat that follows, because the block compares against the prediction in every beat. A rewind that happens at the wrong time only shows on the beat after the run boundary. The bench therefore replays the start values right after full runs, including a run of 1024 beats and a run that crosses the window edge. A lost or stuck flag shows in the cycle after an error beat or a clear pulse, and a wrong counter shows in the cycle after any beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes from the control decode to the datapath, one cycle's worth.
  typedef struct packed {
    logic beatHit;
    logic ldAdr;
    logic ldDat;
    logic ldSize;
    logic clrErr;
    logic clrCnt;
  } seqStrobes_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic              busAck,
  input  logic              spaceSel,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              errClrWe,
  input  logic              cntClrWe,
  output seqStrobes_t       strobes
);
  logic allOnes;

  always_comb begin
    allOnes         = &cfgData;
    strobes.beatHit = busCyc & busStb & busWe & busAck & ~spaceSel;
    strobes.ldAdr   = cfgWe & (cfgSel == 2'd0);
    strobes.ldDat   = cfgWe & (cfgSel == 2'd1);
    strobes.ldSize  = cfgWe & (cfgSel == 2'd2);
    strobes.clrErr  = errClrWe & allOnes;
    strobes.clrCnt  = cntClrWe & allOnes;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIN_W  = 10,
  parameter int SIZE_W = 11,
  parameter int CNT_W  = 16,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              cfgWe,
  input  logic [WIN_W-1:0]  busWord,
  input  logic [DATA_W-1:0] busDat,
  input  logic [DATA_W-1:0] cfgData,
  output logic [STAT_W-1:0] statusWord,
  output logic [CNT_W-1:0]  beatCount
);
  localparam int WORD_LSB = 2;
  localparam logic [SIZE_W-1:0] SIZE_RST = SIZE_W'(1 << WIN_W);

  logic [WIN_W-1:0]  startWord, expWord, nxtStartWord;
  logic [DATA_W-1:0] startDat, expDat, nxtStartDat;
  logic [SIZE_W-1:0] runSize, beatIdx;
  logic              errAdr, errDat, runEnd;

  always_comb begin
    nxtStartWord = strobes.ldAdr ? cfgData[WORD_LSB +: WIN_W] : startWord;
    nxtStartDat  = strobes.ldDat ? cfgData : startDat;
    runEnd       = (beatIdx == runSize - SIZE_W'(1));
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startWord <= '0;
      startDat  <= '0;
      runSize   <= SIZE_RST;
    end else begin
      startWord <= nxtStartWord;
      startDat  <= nxtStartDat;
      if (strobes.ldSize) runSize <= cfgData[SIZE_W-1:0];
    end
  end

  // prediction stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      expWord <= '0;
      expDat  <= '0;
      beatIdx <= '0;
    end else if (cfgWe) begin
      expWord <= nxtStartWord;
      expDat  <= nxtStartDat;
      beatIdx <= '0;
    end else if (strobes.beatHit) begin
      if (runEnd) begin
        expWord <= startWord;
        expDat  <= startDat;
        beatIdx <= '0;
      end else begin
        expWord <= expWord + WIN_W'(1);
        expDat  <= {expDat[DATA_W-2:0], expDat[DATA_W-1]};
        beatIdx <= beatIdx + SIZE_W'(1);
      end
    end
  end

  // sticky flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errAdr <= 1'b0;
      errDat <= 1'b0;
    end else if (strobes.clrErr) begin
      errAdr <= 1'b0;
      errDat <= 1'b0;
    end else if (strobes.beatHit) begin
      if (busWord != expWord) errAdr <= 1'b1;
      if (busDat != expDat)   errDat <= 1'b1;
    end
  end

  // beat counter
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrCnt) beatCount <= '0;
    else if (strobes.beatHit)    beatCount <= beatCount + CNT_W'(1);
  end

  assign statusWord = {{(STAT_W-2){1'b0}}, errAdr, errDat};
endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker
  import burst_seq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WIN_W     = 10,
  parameter int SIZE_W    = 11,
  parameter int CNT_W     = 16,
  parameter int SPACE_BIT = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busCyc,
  input  logic                   busStb,
  input  logic                   busWe,
  input  logic                   busAck,
  input  logic [SPACE_BIT:2]     busAdr,
  input  logic [DATA_W-1:0]      busDat,
  input  logic                   cfgWe,
  input  logic [1:0]             cfgSel,
  input  logic [DATA_W-1:0]      cfgData,
  input  logic                   errClrWe,
  input  logic                   cntClrWe,
  output logic [31:0]            statusWord,
  output logic [CNT_W-1:0]       beatCount
);
  seqStrobes_t strobes;

  seq_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .busCyc(busCyc), .busStb(busStb), .busWe(busWe), .busAck(busAck),
    .spaceSel(busAdr[SPACE_BIT]), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .errClrWe(errClrWe), .cntClrWe(cntClrWe),
    .strobes(strobes)
  );

  seq_datapath #(
    .DATA_W(DATA_W), .WIN_W(WIN_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .STAT_W(32)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWe(cfgWe),
    .busWord(busAdr[2 +: WIN_W]), .busDat(busDat), .cfgData(cfgData),
    .statusWord(statusWord), .beatCount(beatCount)
  );
endmodule

// File: rtl/burst_seq_checker_sva.sv
module burst_seq_checker_sva #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SPACE_BIT = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               busCyc,
  input logic               busStb,
  input logic               busWe,
  input logic               busAck,
  input logic [SPACE_BIT:2] busAdr,
  input logic [DATA_W-1:0]  cfgData,
  input logic               errClrWe,
  input logic               cntClrWe,
  input logic [31:0]        statusWord,
  input logic [CNT_W-1:0]   beatCount
);
  logic hit, errClr, cntClr;
  assign hit    = busCyc & busStb & busWe & busAck & ~busAdr[SPACE_BIT];
  assign errClr = errClrWe & (&cfgData);
  assign cntClr = cntClrWe & (&cfgData);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!hit && !errClr && !cntClr) |=> ($stable(statusWord) && $stable(beatCount))); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:2] == '0); // R5
  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !errClr |=> ((statusWord[1:0] & $past(statusWord[1:0])) == $past(statusWord[1:0]))); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> (statusWord == '0)); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> (beatCount == '0)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !cntClr) |=> (beatCount == $past(beatCount) + CNT_W'(1))); // R7
endmodule

bind burst_seq_checker burst_seq_checker_sva #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .SPACE_BIT(SPACE_BIT)
) uSva (
  .clk(clk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
  .busAck(busAck), .busAdr(busAdr), .cfgData(cfgData), .errClrWe(errClrWe),
  .cntClrWe(cntClrWe), .statusWord(statusWord), .beatCount(beatCount)
);

// File: tb/tb_burst_seq_checker.sv
`timescale 1ns/1ps
module tb_burst_seq_checker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCyc = 0, busStb = 0, busWe = 0, busAck = 0;
  logic [12:2] busAdr = '0;
  logic [31:0] busDat = '0;
  logic cfgWe = 0;
  logic [1:0] cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic errClrWe = 0, cntClrWe = 0;
  logic [31:0] statusWord;
  logic [15:0] beatCount;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_seq_checker dut (
    .clk(clk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busAck(busAck), .busAdr(busAdr), .busDat(busDat), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgData(cfgData), .errClrWe(errClrWe),
    .cntClrWe(cntClrWe), .statusWord(statusWord), .beatCount(beatCount)
  );

  typedef struct {
    logic [31:0] st;
    logic [15:0] cnt;
    string       req;
  } expItem_t;
  expItem_t sb[$];

  // reference model state
  logic [9:0]  mStartW = '0, mWord = '0;
  logic [31:0] mStartD = '0, mDat = '0;
  logic [10:0] mSize = 11'd1024, mIdx = '0;
  logic [1:0]  mFlags = '0;
  logic [15:0] mCnt = '0;

  function automatic logic [31:0] rotl(input logic [31:0] v);
    return {v[30:0], v[31]};
  endfunction

  task automatic rewindModel();
    mWord = mStartW; mDat = mStartD; mIdx = '0;
  endtask

  task automatic pushExp(input string req);
    expItem_t it;
    it.st = {30'd0, mFlags}; it.cnt = mCnt; it.req = req;
    sb.push_back(it);
  endtask

  task automatic setAll(input logic cyc, stb, we, ack, input logic [12:2] a,
                        input logic [31:0] d, input logic cw, input logic [1:0] cs,
                        input logic [31:0] cd, input logic ec, cc);
    busCyc = cyc; busStb = stb; busWe = we; busAck = ack; busAdr = a; busDat = d;
    cfgWe = cw; cfgSel = cs; cfgData = cd; errClrWe = ec; cntClrWe = cc;
  endtask

  // driver: one bus beat, model updated and expectation queued
  task automatic beat(input logic [31:0] byteAdr, input logic [31:0] d,
                      input logic ack, input string req);
    logic hit;
    @(negedge clk);
    setAll(1, 1, 1, ack, byteAdr[12:2], d, 0, 0, 0, 0, 0);
    @(posedge clk);
    hit = ack && !byteAdr[12];
    if (hit) begin
      if (byteAdr[11:2] != mWord) mFlags[1] = 1'b1;
      if (d != mDat)              mFlags[0] = 1'b1;
      mCnt++;
      if (mIdx == mSize - 11'd1) rewindModel();
      else begin
        mWord = mWord + 10'd1; mDat = rotl(mDat); mIdx = mIdx + 11'd1;
      end
    end
    pushExp(req);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d, input string req);
    @(negedge clk);
    setAll(0, 0, 0, 0, '0, '0, 1, sel, d, 0, 0);
    @(posedge clk);
    if (sel == 2'd0) mStartW = d[11:2];
    else if (sel == 2'd1) mStartD = d;
    else if (sel == 2'd2) mSize = d[10:0];
    rewindModel();
    pushExp(req);
  endtask

  task automatic clrErr(input logic [31:0] d, input string req);
    @(negedge clk);
    setAll(0, 0, 0, 0, '0, '0, 0, 0, d, 1, 0);
    @(posedge clk);
    if (&d) mFlags = '0;
    pushExp(req);
  endtask

  task automatic clrCnt(input logic [31:0] d, input string req);
    @(negedge clk);
    setAll(0, 0, 0, 0, '0, '0, 0, 0, d, 0, 1);
    @(posedge clk);
    if (&d) mCnt = '0;
    pushExp(req);
  endtask

  task automatic idle();
    @(negedge clk);
    setAll(0, 0, 0, 0, '0, '0, 0, 0, '0, 0, 0);
  endtask

  // full correct run from the current prediction
  task automatic goodRun(input int n, input string req);
    logic [9:0] w; logic [31:0] d; logic [10:0] k;
    w = mWord; d = mDat; k = mIdx;
    for (int i = 0; i < n; i++) begin
      beat({19'd0, 1'b0, w, 2'b00}, d, 1'b1, req);
      if (k == mSize - 11'd1 || i == n - 1) begin
        w = mWord; d = mDat; k = mIdx;
      end else begin
        w = w + 10'd1; d = rotl(d); k = k + 11'd1;
      end
    end
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      checks++;
      if (statusWord !== it.st || beatCount !== it.cnt) begin
        errors++;
        $display("FAIL %s: status=%h count=%0d expected status=%h count=%0d",
                 it.req, statusWord, beatCount, it.st, it.cnt);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expired, expected run to complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (statusWord !== 32'd0 || beatCount !== 16'd0) begin
      errors++;
      $display("FAIL R9: status=%h count=%0d expected 0/0", statusWord, beatCount);
    end
    // R9: reset start values 0, size 1024: beat at word 0 data 0 is clean
    beat(32'h0, 32'h0, 1, "R9");
    // R8 R2 R3: program start, then four clean beats
    cfg(2'd0, 32'h0000_0F00, "R8");
    cfg(2'd1, 32'h8000_0001, "R8");
    cfg(2'd2, 32'd4, "R8");
    cfg(2'd3, 32'hFFFF_FFFF, "R8");
    goodRun(4, "R2");
    // R4: repeat of the start values after the run raises nothing
    beat(32'h0000_0F00, 32'h8000_0001, 1, "R4");
    // R1: no ack, and register space, are ignored
    beat(32'h0000_0ABC, 32'h1234_5678, 0, "R1");
    beat(32'h0000_1F04, 32'hDEAD_BEEF, 1, "R1");
    // R3: data error only
    beat(32'h0000_0F04, 32'h0000_0000, 1, "R3");
    clrErr(32'hFFFF_FFFE, "R6");
    goodRun(2, "R6");
    clrErr(32'hFFFF_FFFF, "R6");
    // R2: address error only
    cfg(2'd2, 32'd4, "R8");
    beat(32'h0000_0F04, 32'h8000_0001, 1, "R2");
    clrErr(32'hFFFF_FFFF, "R6");
    // R5: both in one beat, then sticky through clean beats
    cfg(2'd2, 32'd4, "R8");
    beat(32'h0000_0F10, 32'h0000_0002, 1, "R5");
    goodRun(3, "R6");
    goodRun(4, "R6");
    clrErr(32'hFFFF_FFFF, "R6");
    // R7: counter clear needs all ones
    clrCnt(32'h7FFF_FFFF, "R7");
    clrCnt(32'hFFFF_FFFF, "R7");
    // R2: window wrap at word 1023 -> 0
    cfg(2'd0, 32'h0000_0FF8, "R2");
    cfg(2'd1, 32'hA5A5_0F0F, "R3");
    cfg(2'd2, 32'd3, "R4");
    goodRun(3, "R2");
    beat(32'h0000_0FF8, 32'hA5A5_0F0F, 1, "R4");
    // R4: longest run, then the start values again
    cfg(2'd0, 32'h0000_0010, "R8");
    cfg(2'd2, 32'd1024, "R4");
    goodRun(1024, "R4");
    beat(32'h0000_0010, 32'hA5A5_0F0F, 1, "R4");
    // R8: mid-run config write restarts the prediction
    goodRun(5, "R8");
    cfg(2'd3, 32'h0, "R8");
    beat(32'h0000_0010, 32'hA5A5_0F0F, 1, "R8");
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule